// File: doc/BRIEF.md
# Programmable Reference and Feedback Dividers for a Frequency Synthesizer

This block turns three configuration bytes into the two divide ratios of a frequency synthesizer's loop, then runs both ratios as programmable counters. The reference counter runs on the input reference clock and divides it by Qtotal. The feedback counter runs on the oscillator-rate clock and divides it by Ptotal, which may be an odd number. For each counter, the block drives a one-cycle pulse once per period and a near-square wave. It also decodes a 3-bit charge-pump code and exports it for the loop filter logic outside this block.

The three bytes are named after their roles. `cfgHi` carries the charge-pump code and the top bits of the feedback field. `cfgLo` carries the low byte of the feedback field. `cfgMix` carries the reference field and the odd bit of the feedback ratio. A one-cycle `loadStb` stores the decoded ratios as pending values. Each counter changes to its pending ratio only when its current period ends, so no period is ever cut short. While reset is active, both counters take the ratios decoded from the bytes present at that time.

`rstN` is sampled synchronously in each clock domain. The configuration bytes must be held steady while `loadStb` is high, and the strobe must be seen by both clocks.

Top module: `pll_ratio_div`

## Requirements
- R1: `refRatio` equals Qtotal = cfgMix[6:0] + 2, so it ranges from 2 to 129.
- R2: `fbRatio` equals Ptotal = 2*(PB + 4) + PO. PB = {cfgHi[1:0], cfgLo[7:0]} and PO = cfgMix[7]. The range runs from 8 (PB = 0, PO = 0) to 2055 (PB = 1023, PO = 1).
- R3: `pumpSel` equals cfgHi[4:2]. It is taken during reset and in the cycle after `loadStb`, and it holds at all other times. cfgHi[7:5] have no effect on any output.
- R4: `refPulse` is high for exactly one `refClk` cycle in every Qtotal cycles.
- R5: `fbPulse` is high for exactly one `vcoClk` cycle in every Ptotal cycles, for odd and for even ratios.
- R6: In each period of N cycles, each square output is high for floor(N/2) cycles and low for the rest. It is low in the cycle where the pulse is high.
- R7: A `loadStb` that arrives in the middle of a period leaves the exported ratio and the length of the current period unchanged. The new ratio applies from the next period onward.
- R8: A `loadStb` that falls in the cycle of a counter's terminal count applies the new ratio to the period that follows at once.
- R9: While `rstN` is low, both pulses are low and both counters sit at zero. After release, a counter with ratio N gives its first pulse once N-1 rising edges have occurred with reset high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock, divided by Qtotal |
| vcoClk | input | 1 | Oscillator-rate clock, divided by Ptotal |
| rstN | input | 1 | Active-low reset, synchronous in each domain |
| loadStb | input | 1 | Stores the ratios decoded from the bytes as pending values |
| cfgHi | input | 8 | Charge-pump code [4:2], feedback field bits 9:8 in [1:0], [7:5] reserved |
| cfgLo | input | 8 | Feedback field bits 7:0 |
| cfgMix | input | 8 | Odd feedback bit [7], reference field [6:0] |
| refPulse | output | 1 | One-cycle pulse per reference period |
| refSquare | output | 1 | Near-square reference divider output |
| fbPulse | output | 1 | One-cycle pulse per feedback period |
| fbSquare | output | 1 | Near-square feedback divider output |
| refRatio | output | 8 | Active reference divide ratio |
| fbRatio | output | 12 | Active feedback divide ratio |
| pumpSel | output | 3 | Registered charge-pump code |

## Verification
Decoded ratios and the pump code are read one falling edge after a capturing rising edge. That edge is the reset edge or the edge where `loadStb` is seen. A pulse is due N-1 rising edges after its counter wraps. The bench samples every output on the falling edge, so each result is counted in whole cycles from the edge that caused it. For a load in mid-period, the bench counts the falling edges from one pulse to the next, which shows the old period length followed by the new one. For a load that falls on the terminal count, the strobe is driven on the falling edge where the pulse is visible, and the period that follows is measured.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  // raw field geometry
  localparam int BYTE_W   = 8;
  localparam int Q_W      = 7;
  localparam int PB_W     = 10;
  localparam int PB_HI_W  = PB_W - BYTE_W;
  localparam int PUMP_W   = 3;
  localparam int PUMP_LSB = 2;
  localparam int ODD_BIT  = BYTE_W - 1;

  // ratio offsets and derived ranges
  localparam int Q_OFFSET  = 2;
  localparam int PB_OFFSET = 4;
  localparam int REF_MIN   = Q_OFFSET;
  localparam int REF_MAX   = (1 << Q_W) - 1 + Q_OFFSET;
  localparam int FB_MIN    = 2 * PB_OFFSET;
  localparam int FB_MAX    = 2 * ((1 << PB_W) - 1 + PB_OFFSET) + 1;
  localparam int REF_W     = $clog2(REF_MAX + 1);
  localparam int FB_W      = $clog2(FB_MAX + 1);

  // strobes from a counter's control to its datapath
  typedef struct packed {
    logic capture;    // store the freshly decoded ratio as pending
    logic reload;     // terminal count: wrap and switch ratio
    logic takeFresh;  // capture and reload coincide: switch straight to the new ratio
  } divStrobe_t;
endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
  import pll_div_pkg::*;
(
  input  logic [BYTE_W-1:0] cfgHi,
  input  logic [BYTE_W-1:0] cfgLo,
  input  logic [BYTE_W-1:0] cfgMix,
  output logic [REF_W-1:0]  qTotal,
  output logic [FB_W-1:0]   pTotal,
  output logic [PUMP_W-1:0] pumpCode
);
  logic [Q_W-1:0]  qField;
  logic [PB_W-1:0] pbField;
  logic            oddBit;

  always_comb begin
    qField   = cfgMix[Q_W-1:0];
    oddBit   = cfgMix[ODD_BIT];
    pbField  = {cfgHi[PB_HI_W-1:0], cfgLo};
    qTotal   = REF_W'(qField) + REF_W'(Q_OFFSET);
    pTotal   = FB_W'({pbField, 1'b0}) + FB_W'(FB_MIN) + FB_W'(oddBit);
    // reserved upper bits of cfgHi are deliberately not referenced
    pumpCode = cfgHi[PUMP_LSB +: PUMP_W];
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import pll_div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadStb,
  input  logic [W-1:0] count,
  input  logic [W-1:0] activeRatio,
  output divStrobe_t   strobe,
  output logic         pulseOut,
  output logic         squareOut
);
  logic termHit;

  always_comb begin
    termHit          = (count == activeRatio - W'(1));
    strobe.capture   = loadStb;
    strobe.reload    = termHit;
    strobe.takeFresh = loadStb & termHit;
    pulseOut         = termHit;
    squareOut        = (count < (activeRatio >> 1));
  end

  // R6: the square output is low while the pulse is high
  p_square_low_on_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |-> !squareOut);

  // R4/R5: the pulse never lasts longer than one cycle
  p_single_cycle_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |=> !pulseOut);
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import pll_div_pkg::*;
#(
  parameter int W    = 8,
  parameter int MINR = 2,
  parameter int MAXR = 129
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobe_t   strobe,
  input  logic [W-1:0] freshRatio,
  output logic [W-1:0] count,
  output logic [W-1:0] activeRatio
);
  logic [W-1:0] pendRatio;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= '0;
      activeRatio <= freshRatio;
      pendRatio   <= freshRatio;
    end else begin
      if (strobe.capture) pendRatio <= freshRatio;
      if (strobe.reload) begin
        count       <= '0;
        activeRatio <= strobe.takeFresh ? freshRatio : pendRatio;
      end else begin
        count <= count + W'(1);
      end
    end
  end

  // R4: the count stays inside the active period
  p_count_in_period_r4: assert property (@(posedge clk) disable iff (!rstN)
    count < activeRatio);

  // R1/R2: the active ratio stays inside its legal range
  p_ratio_bounds_r1: assert property (@(posedge clk) disable iff (!rstN)
    (activeRatio >= W'(MINR)) && (activeRatio <= W'(MAXR)));

  // R7: the ratio changes only after a terminal count
  p_ratio_only_at_term_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.reload |=> $stable(activeRatio));

  // R4: a terminal count wraps the counter to zero
  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (count == '0));
endmodule

// File: rtl/div_unit.sv
module div_unit
  import pll_div_pkg::*;
#(
  parameter int W    = 8,
  parameter int MINR = 2,
  parameter int MAXR = 129
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadStb,
  input  logic [W-1:0] freshRatio,
  output logic         pulseOut,
  output logic         squareOut,
  output logic [W-1:0] ratioOut
);
  divStrobe_t   strobe;
  logic [W-1:0] count;

  div_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb),
    .count(count), .activeRatio(ratioOut),
    .strobe(strobe), .pulseOut(pulseOut), .squareOut(squareOut)
  );

  div_datapath #(.W(W), .MINR(MINR), .MAXR(MAXR)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .freshRatio(freshRatio),
    .count(count), .activeRatio(ratioOut)
  );
endmodule

// File: rtl/pll_ratio_div.sv
module pll_ratio_div
  import pll_div_pkg::*;
(
  input  logic              refClk,
  input  logic              vcoClk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [BYTE_W-1:0] cfgHi,
  input  logic [BYTE_W-1:0] cfgLo,
  input  logic [BYTE_W-1:0] cfgMix,
  output logic              refPulse,
  output logic              refSquare,
  output logic              fbPulse,
  output logic              fbSquare,
  output logic [REF_W-1:0]  refRatio,
  output logic [FB_W-1:0]   fbRatio,
  output logic [PUMP_W-1:0] pumpSel
);
  logic [REF_W-1:0]  qTotal;
  logic [FB_W-1:0]   pTotal;
  logic [PUMP_W-1:0] pumpCode;

  cfg_decode u_decode (
    .cfgHi(cfgHi), .cfgLo(cfgLo), .cfgMix(cfgMix),
    .qTotal(qTotal), .pTotal(pTotal), .pumpCode(pumpCode)
  );

  div_unit #(.W(REF_W), .MINR(REF_MIN), .MAXR(REF_MAX)) u_refDiv (
    .clk(refClk), .rstN(rstN), .loadStb(loadStb), .freshRatio(qTotal),
    .pulseOut(refPulse), .squareOut(refSquare), .ratioOut(refRatio)
  );

  div_unit #(.W(FB_W), .MINR(FB_MIN), .MAXR(FB_MAX)) u_fbDiv (
    .clk(vcoClk), .rstN(rstN), .loadStb(loadStb), .freshRatio(pTotal),
    .pulseOut(fbPulse), .squareOut(fbSquare), .ratioOut(fbRatio)
  );

  always_ff @(posedge refClk) begin
    if (!rstN || loadStb) pumpSel <= pumpCode;
  end

  // R3: the pump code holds unless a load strobe was seen
  p_pump_hold_r3: assert property (@(posedge refClk) disable iff (!rstN)
    !loadStb |=> $stable(pumpSel));
endmodule

// File: tb/pll_ratio_div_bench.sv
`timescale 1ns/1ps
module pll_ratio_div_bench;
  logic clk = 1'b0;
  logic rstN, loadStb;
  logic [7:0] cfgHi, cfgLo, cfgMix;
  logic refPulse, refSquare, fbPulse, fbSquare;
  logic [7:0]  refRatio;
  logic [11:0] fbRatio;
  logic [2:0]  pumpSel;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pll_ratio_div u_pll_ratio_div (
    .refClk(clk), .vcoClk(clk), .rstN(rstN), .loadStb(loadStb),
    .cfgHi(cfgHi), .cfgLo(cfgLo), .cfgMix(cfgMix),
    .refPulse(refPulse), .refSquare(refSquare), .fbPulse(fbPulse), .fbSquare(fbSquare),
    .refRatio(refRatio), .fbRatio(fbRatio), .pumpSel(pumpSel)
  );

  typedef struct packed {
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [7:0]  mix;
    logic [7:0]  expQ;
    logic [11:0] expP;
    logic [2:0]  expPump;
    logic [31:0] refHz;
    logic        expOk;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'hC0, 8'h00, 8'h00, 8'd2,   12'd8,    3'd0, 32'd25_000_000, 1'b1},
    '{8'hDF, 8'hFF, 8'h80, 8'd2,   12'd2055, 3'd7, 32'd25_000_000, 1'b0},
    '{8'h1F, 8'hFF, 8'h80, 8'd2,   12'd2055, 3'd7, 32'd25_000_000, 1'b0},
    '{8'hC8, 8'h0A, 8'h85, 8'd7,   12'd29,   3'd2, 32'd70_000_000, 1'b1},
    '{8'hD5, 8'h2C, 8'h7F, 8'd129, 12'd608,  3'd5, 32'd50_000_000, 1'b1},
    '{8'hE6, 8'h01, 8'h13, 8'd21,  12'd1034, 3'd1, 32'd20_000_000, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // operating-range helper: ref/Qtotal >= 250 kHz and the oscillator rate within 100..400 MHz
  function automatic bit freqOk(input longint refHz, input longint q, input longint p);
    return (refHz >= 64'd250_000 * q) &&
           (p * refHz >= 64'd100_000_000 * q) &&
           (p * refHz <= 64'd400_000_000 * q);
  endfunction

  task automatic measure(input bit useFb, output int period, output int highs);
    do @(negedge clk); while (!(useFb ? fbPulse : refPulse));
    period = 0;
    highs  = 0;
    do begin
      @(negedge clk);
      period++;
      if (useFb ? fbSquare : refSquare) highs++;
    end while (!(useFb ? fbPulse : refPulse));
  endtask

  task automatic applyReset(input logic [7:0] h, input logic [7:0] l, input logic [7:0] m);
    @(negedge clk);
    rstN = 1'b0; cfgHi = h; cfgLo = l; cfgMix = m;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, hi, c;
    rstN = 1'b0; loadStb = 1'b0; cfgHi = 8'hC0; cfgLo = 8'h00; cfgMix = 8'h00;

    // table walk: decode, range helper, periods and duty
    for (int v = 0; v < NVEC; v++) begin
      applyReset(VECS[v].hi, VECS[v].lo, VECS[v].mix);
      check(refPulse == 1'b0 && fbPulse == 1'b0, "R9 pulses low in reset", int'(refPulse) + int'(fbPulse), 0);
      check(refRatio == VECS[v].expQ, "R1 reference ratio", refRatio, VECS[v].expQ);
      check(fbRatio == VECS[v].expP, "R2 feedback ratio", fbRatio, VECS[v].expP);
      check(pumpSel == VECS[v].expPump, "R3 pump code (reserved bits ignored)", pumpSel, VECS[v].expPump);
      check(freqOk(VECS[v].refHz, VECS[v].expQ, VECS[v].expP) == VECS[v].expOk, "R2 operating range",
            freqOk(VECS[v].refHz, VECS[v].expQ, VECS[v].expP), VECS[v].expOk);
      rstN = 1'b1;
      measure(1'b0, per, hi);
      check(per == VECS[v].expQ, "R4 reference period", per, VECS[v].expQ);
      check(hi == VECS[v].expQ / 2, "R6 reference high time", hi, VECS[v].expQ / 2);
      measure(1'b1, per, hi);
      check(per == VECS[v].expP, "R5 feedback period", per, VECS[v].expP);
      check(hi == VECS[v].expP / 2, "R6 feedback high time", hi, VECS[v].expP / 2);
    end

    // R9: first pulse after N-1 rising edges with reset high
    applyReset(8'hC8, 8'h0A, 8'h85);
    rstN = 1'b1;
    c = 0;
    do begin @(negedge clk); c++; end while (!refPulse);
    check(c == 6, "R9 first reference pulse", c, 6);

    // R7: mid-period load keeps the current period and ratio
    c = 0;
    repeat (2) begin @(negedge clk); c++; end
    loadStb = 1'b1; cfgHi = 8'hCC; cfgMix = 8'h08;
    @(negedge clk); c++;
    loadStb = 1'b0;
    check(refRatio == 8'd7, "R7 ratio held until terminal", refRatio, 7);
    check(pumpSel == 3'd3, "R3 pump updated after strobe", pumpSel, 3);
    while (!refPulse) begin @(negedge clk); c++; end
    check(c == 7, "R7 current period unchanged", c, 7);
    measure(1'b0, per, hi);
    check(per == 10, "R7 new ratio in next period", per, 10);
    check(refRatio == 8'd10, "R7 ratio switched", refRatio, 10);

    // R8: load coincident with the terminal count (pulse visible now)
    loadStb = 1'b1; cfgMix = 8'h00;
    @(negedge clk);
    loadStb = 1'b0;
    check(refRatio == 8'd2, "R8 immediate ratio", refRatio, 2);
    c = 1;
    while (!refPulse) begin @(negedge clk); c++; end
    check(c == 2, "R8 immediate period", c, 2);
    measure(1'b0, per, hi);
    check(hi == 1, "R6 high time at ratio 2", hi, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule